// File: doc/BRIEF.md
# I2C Master Controller Register and Interrupt Block

This block is the register file of an I2C master controller. It decodes 16-bit register reads and writes at fixed byte offsets and holds the configuration the transfer logic needs: control, own and target addresses, transfer count, prescaler and the two clock-phase timing values. It also holds the interrupt-enable register and the DMA setup. The prescaler and timing registers are only stored; this block does not interpret them.

The status register is owned here. A separate transfer sequencer sets and clears its bits through per-bit set and clear strobes. From the status and the enables, the block drives one level interrupt line and two DMA request lines. The data register, its byte buffer and the bus signalling live elsewhere. At this block the data offset reads zero and ignores writes.

A parameter selects the register revision. An older revision (below 0x34) has a 5-bit interrupt enable and a read-only status register. It also has a vector register that reports, and then acknowledges, the lowest pending enabled source. A newer revision has a 6-bit enable and write-one-to-clear status, and it can force status bits through the system-test register.

Top module: `i2cm_regfile`

## Requirements
- R1: After a synchronous reset every register reads 0x0000. The interrupt, both DMA requests, the read data and all configuration outputs are low.
- R2: An interrupt-enable write (offset 0x04) keeps bits 4:0 when REV_ID is below 0x34 and keeps bits 5:0 otherwise.
- R3: `irq` is high exactly when some bit of (status AND interrupt enable) is set, and it follows any change of either in the same clock edge.
- R4: A DMA-setup write (offset 0x14) keeps only bits 15 and 7. Writing bit 15 as 1 clears interrupt-enable bit 3. Writing bit 7 as 1 clears interrupt-enable bit 4.
- R5: `dma_rx_req` equals DMA bit 15 AND status bit 3 (receive ready). `dma_tx_req` equals DMA bit 7 AND status bit 4 (transmit ready).
- R6: Status bits 15, 11, 10 and 5:0 are stored. A set strobe sets its bit, and a clear strobe clears it. When both strobes hit the same bit in one cycle, the set wins. A status read (offset 0x08) returns `bus_busy` in bit 12.
- R7: With REV_ID at or above 0x34, writing 1 to a status bit clears it and writing 0 leaves it. Below 0x34, status writes change nothing.
- R8: A control write (offset 0x24) is masked with 0xCF87. Own-address (0x28) and target-address (0x2C) writes are masked to 0x03FF. Count (0x18), prescaler (0x30), clock-low (0x34) and clock-high (0x38) store all 16 bits. Each value appears on its output port.
- R9: Offset 0x00 reads REV_ID. Offset 0x10 reads control bit 15 in bit 0. Offsets 0x1C and 0x20 read 0x0000. Writes to 0x00, 0x0C and 0x10 change nothing.
- R10: With REV_ID below 0x34, a read of offset 0x0C returns the index of the lowest set bit of (status AND enable), or 0 when none is set. The read clears that status bit. At or above 0x34 the read returns 0 and clears nothing.
- R11: A system-test write (offset 0x3C) is masked with 0xF80F. While its bit 15 is set, each read first XORs the stored value with 0x000A and returns the new value. While bit 15 is clear, a read returns the stored value and leaves it unchanged.
- R12: With REV_ID at or above 0x34, a system-test write with bit 11 set also sets status bits 5:0. Below 0x34 it leaves the status unchanged.
- R13: `reg_rdata` is loaded at the clock edge that samples `reg_rd` and holds its value in every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| seq_set | input | 16 | Per-bit status set strobes from the sequencer |
| seq_clr | input | 16 | Per-bit status clear strobes from the sequencer |
| bus_busy | input | 1 | Bus-busy state, shown in status bit 12 |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| ctrl_out | output | 16 | Control register |
| own_addr | output | 16 | Own address (bits 9:0 used) |
| tgt_addr | output | 16 | Target address (bits 9:0 used) |
| xfer_count | output | 16 | Transfer count |
| prescale | output | 16 | Prescaler value |
| scl_low | output | 16 | Clock low-phase time |
| scl_high | output | 16 | Clock high-phase time |

## Verification
On every cycle the assertions check that the interrupt level matches status AND enable, and that each DMA request tracks its enable and ready bit. They also check that a set strobe beats a simultaneous clear, that a DMA write drops the matching enable, that a vector read clears the bit it reported, that each self-test read toggles the stored value, and that the read data holds without a read. Only the bench scenarios show the write masks and the read-only offsets. They also cover the differences between the two revisions side by side: enable width, status write-to-clear, vector walk-down and the forced status fill.

// File: rtl/i2cm_regfile_pkg.sv
package i2cm_regfile_pkg;

  localparam int REG_W = 16;

  // register byte offsets
  localparam logic [7:0] OFF_REV  = 8'h00;
  localparam logic [7:0] OFF_IE   = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_VEC  = 8'h0C;
  localparam logic [7:0] OFF_SYSS = 8'h10;
  localparam logic [7:0] OFF_DMA  = 8'h14;
  localparam logic [7:0] OFF_CNT  = 8'h18;
  localparam logic [7:0] OFF_DATA = 8'h1C;
  localparam logic [7:0] OFF_SYSC = 8'h20;
  localparam logic [7:0] OFF_CTRL = 8'h24;
  localparam logic [7:0] OFF_OWN  = 8'h28;
  localparam logic [7:0] OFF_TGT  = 8'h2C;
  localparam logic [7:0] OFF_PSC  = 8'h30;
  localparam logic [7:0] OFF_SCLL = 8'h34;
  localparam logic [7:0] OFF_SCLH = 8'h38;
  localparam logic [7:0] OFF_TEST = 8'h3C;

  // revision at which the newer register behaviour begins
  localparam logic [15:0] REV_SPLIT = 16'h0034;

  localparam logic [REG_W-1:0] STAT_KEEP = 16'h8C3F;
  localparam logic [REG_W-1:0] DMA_KEEP  = 16'h8080;
  localparam logic [REG_W-1:0] TEST_KEEP = 16'hF80F;
  localparam logic [REG_W-1:0] TEST_FLIP = 16'h000A;
  localparam logic [REG_W-1:0] SBB_FILL  = 16'h003F;

  localparam int B_RRDY   = 3;
  localparam int B_XRDY   = 4;
  localparam int B_BUSY   = 12;
  localparam int B_RXDMA  = 15;
  localparam int B_TXDMA  = 7;
  localparam int B_ENABLE = 15;
  localparam int B_TSTEN  = 15;
  localparam int B_FILL   = 11;

  // plain storage registers
  localparam int CFG_N    = 7;
  localparam int CFG_CTRL = 0;
  localparam int CFG_OWN  = 1;
  localparam int CFG_TGT  = 2;
  localparam int CFG_CNT  = 3;
  localparam int CFG_PSC  = 4;
  localparam int CFG_SCLL = 5;
  localparam int CFG_SCLH = 6;

  function automatic logic [7:0] cfg_off(input int idx);
    case (idx)
      CFG_CTRL: cfg_off = OFF_CTRL;
      CFG_OWN:  cfg_off = OFF_OWN;
      CFG_TGT:  cfg_off = OFF_TGT;
      CFG_CNT:  cfg_off = OFF_CNT;
      CFG_PSC:  cfg_off = OFF_PSC;
      CFG_SCLL: cfg_off = OFF_SCLL;
      default:  cfg_off = OFF_SCLH;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_keep(input int idx);
    case (idx)
      CFG_CTRL:         cfg_keep = 16'hCF87;
      CFG_OWN, CFG_TGT: cfg_keep = 16'h03FF;
      default:          cfg_keep = 16'hFFFF;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_low_enc.sv
module i2cm_low_enc #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [N-1:0]  first,
  output logic [IW-1:0] idx
);

  // lowest set bit wins
  always_comb begin
    hit   = 1'b0;
    first = '0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !hit) begin
        hit      = 1'b1;
        first[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end

endmodule

// File: rtl/i2cm_irq_core.sv
module i2cm_irq_core
  import i2cm_regfile_pkg::*;
#(
  parameter bit NEW_REV = 1'b1,
  parameter int IE_W    = 6,
  parameter int IW      = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ie_we,
  input  logic             dma_we,
  input  logic             stat_we,
  input  logic             vec_rd,
  input  logic             fill_set,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] seq_set,
  input  logic [REG_W-1:0] seq_clr,
  output logic [REG_W-1:0] ie_q,
  output logic [REG_W-1:0] dma_q,
  output logic [REG_W-1:0] stat_q,
  output logic [IW-1:0]    vec_idx,
  output logic             irq_o,
  output logic             dma_rx_o,
  output logic             dma_tx_o
);

  localparam logic [REG_W-1:0] IE_KEEP = REG_W'((1 << IE_W) - 1);

  logic [IE_W-1:0]  pend;
  logic [IE_W-1:0]  first;
  logic             hit;
  logic [REG_W-1:0] first_w;
  logic [REG_W-1:0] ie_d, dma_d, stat_d, clr_all, set_all;

  assign pend    = stat_q[IE_W-1:0] & ie_q[IE_W-1:0];
  assign first_w = REG_W'(first);

  i2cm_low_enc #(.N(IE_W), .IW(IW)) u_enc (
    .req  (pend),
    .hit  (hit),
    .first(first),
    .idx  (vec_idx)
  );

  always_comb begin
    ie_d  = ie_q;
    dma_d = dma_q;
    if (ie_we) ie_d = wdata & IE_KEEP;
    if (dma_we) begin
      dma_d = wdata & DMA_KEEP;
      if (wdata[B_RXDMA]) ie_d[B_RRDY] = 1'b0;
      if (wdata[B_TXDMA]) ie_d[B_XRDY] = 1'b0;
    end
    clr_all = seq_clr;
    if (stat_we) clr_all = clr_all | wdata;
    if (vec_rd && hit) clr_all = clr_all | first_w;
    set_all = seq_set;
    if (fill_set) set_all = set_all | SBB_FILL;
    stat_d = ((stat_q & ~clr_all) | set_all) & STAT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= '0;
      dma_q    <= '0;
      stat_q   <= '0;
      irq_o    <= 1'b0;
      dma_rx_o <= 1'b0;
      dma_tx_o <= 1'b0;
    end else begin
      ie_q     <= ie_d;
      dma_q    <= dma_d;
      stat_q   <= stat_d;
      irq_o    <= |(stat_d & ie_d);
      dma_rx_o <= dma_d[B_RXDMA] & stat_d[B_RRDY];
      dma_tx_o <= dma_d[B_TXDMA] & stat_d[B_XRDY];
    end
  end

  p_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(stat_q & ie_q)));

  p_rx_follow_r5: assert property (@(posedge clk) disable iff (rst)
    dma_rx_o == (dma_q[B_RXDMA] && stat_q[B_RRDY]));

  p_tx_follow_r5: assert property (@(posedge clk) disable iff (rst)
    dma_tx_o == (dma_q[B_TXDMA] && stat_q[B_XRDY]));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (|(seq_set & STAT_KEEP)) |=>
      ((stat_q & $past(seq_set & STAT_KEEP)) == $past(seq_set & STAT_KEEP)));

  p_dma_drops_ie_r4: assert property (@(posedge clk) disable iff (rst)
    (dma_we && wdata[B_RXDMA]) |=> !ie_q[B_RRDY]);

  p_vec_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && hit && !(|(seq_set & first_w)) && !fill_set) |=>
      !(|(stat_q & $past(first_w))));

endmodule

// File: rtl/i2cm_cfg_bank.sv
module i2cm_cfg_bank
  import i2cm_regfile_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [REG_W-1:0]            wdata,
  output logic [CFG_N-1:0][REG_W-1:0] cfg_q,
  output logic [REG_W-1:0]            test_q,
  output logic [REG_W-1:0]            test_rd
);

  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    localparam logic [ADDR_W-1:0] MY_OFF  = ADDR_W'(cfg_off(i));
    localparam logic [REG_W-1:0]  MY_KEEP = cfg_keep(i);
    logic [REG_W-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst) val_q <= '0;
      else if (wr && addr == MY_OFF) val_q <= wdata & MY_KEEP;
    end
    assign cfg_q[i] = val_q;
  end

  logic tst_hit;
  assign tst_hit = (addr == ADDR_W'(OFF_TEST));

  always_ff @(posedge clk) begin
    if (rst) test_q <= '0;
    else if (wr && tst_hit) test_q <= wdata & TEST_KEEP;
    else if (rd && tst_hit && test_q[B_TSTEN]) test_q <= test_q ^ TEST_FLIP;
  end

  assign test_rd = test_q[B_TSTEN] ? (test_q ^ TEST_FLIP) : test_q;

  p_test_toggle_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr && tst_hit && test_q[B_TSTEN]) |=>
      (test_q == ($past(test_q) ^ TEST_FLIP)));

  p_test_still_r11: assert property (@(posedge clk) disable iff (rst)
    (!wr && !(rd && test_q[B_TSTEN])) |=> $stable(test_q));

endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
  import i2cm_regfile_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter logic [15:0] REV_ID = 16'h0034
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [15:0]       seq_set,
  input  logic [15:0]       seq_clr,
  input  logic              bus_busy,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req,
  output logic [15:0]       ctrl_out,
  output logic [15:0]       own_addr,
  output logic [15:0]       tgt_addr,
  output logic [15:0]       xfer_count,
  output logic [15:0]       prescale,
  output logic [15:0]       scl_low,
  output logic [15:0]       scl_high
);

  localparam bit NEW_REV = (REV_ID >= REV_SPLIT);
  localparam int IE_W    = NEW_REV ? 6 : 5;
  localparam int IW      = $clog2(IE_W);

  logic [CFG_N-1:0][REG_W-1:0] cfg_q;
  logic [REG_W-1:0] test_q, test_rd;
  logic [REG_W-1:0] ie_q, dma_q, stat_q;
  logic [IW-1:0]    vec_idx;
  logic [REG_W-1:0] rd_mux;

  logic at_ie, at_stat, at_vec, at_dma, at_test;
  assign at_ie   = (reg_addr == ADDR_W'(OFF_IE));
  assign at_stat = (reg_addr == ADDR_W'(OFF_STAT));
  assign at_vec  = (reg_addr == ADDR_W'(OFF_VEC));
  assign at_dma  = (reg_addr == ADDR_W'(OFF_DMA));
  assign at_test = (reg_addr == ADDR_W'(OFF_TEST));

  i2cm_irq_core #(.NEW_REV(NEW_REV), .IE_W(IE_W), .IW(IW)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ie_we   (reg_wr && at_ie),
    .dma_we  (reg_wr && at_dma),
    .stat_we (NEW_REV && reg_wr && at_stat),
    .vec_rd  (!NEW_REV && reg_rd && at_vec),
    .fill_set(NEW_REV && reg_wr && at_test && reg_wdata[B_FILL]),
    .wdata   (reg_wdata),
    .seq_set (seq_set),
    .seq_clr (seq_clr),
    .ie_q    (ie_q),
    .dma_q   (dma_q),
    .stat_q  (stat_q),
    .vec_idx (vec_idx),
    .irq_o   (irq),
    .dma_rx_o(dma_rx_req),
    .dma_tx_o(dma_tx_req)
  );

  i2cm_cfg_bank #(.ADDR_W(ADDR_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .cfg_q  (cfg_q),
    .test_q (test_q),
    .test_rd(test_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFF_REV))  rd_mux = REV_ID;
    if (at_ie)                         rd_mux = ie_q;
    if (at_stat) begin
      rd_mux         = stat_q;
      rd_mux[B_BUSY] = bus_busy;
    end
    if (at_vec && !NEW_REV)            rd_mux = REG_W'(vec_idx);
    if (reg_addr == ADDR_W'(OFF_SYSS)) rd_mux = REG_W'(cfg_q[CFG_CTRL][B_ENABLE]);
    if (at_dma)                        rd_mux = dma_q;
    if (at_test)                       rd_mux = test_rd;
    for (int i = 0; i < CFG_N; i++) begin
      if (reg_addr == ADDR_W'(cfg_off(i))) rd_mux = cfg_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign ctrl_out   = cfg_q[CFG_CTRL];
  assign own_addr   = cfg_q[CFG_OWN];
  assign tgt_addr   = cfg_q[CFG_TGT];
  assign xfer_count = cfg_q[CFG_CNT];
  assign prescale   = cfg_q[CFG_PSC];
  assign scl_low    = cfg_q[CFG_SCLL];
  assign scl_high   = cfg_q[CFG_SCLH];

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));

  p_rev_read_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(OFF_REV)) |=> (reg_rdata == REV_ID));

  p_busy_bit_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && at_stat) |=> (reg_rdata[B_BUSY] == $past(bus_busy)));

endmodule

// File: tb/test_i2cm_regfile.sv
module test_i2cm_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, bus_busy = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, seq_set = '0, seq_clr = '0;
  logic [15:0] rd_new, rd_old;
  logic        irq_new, rx_new, tx_new, irq_old, rx_old, tx_old;
  logic [15:0] ctrl_n, own_n, tgt_n, cnt_n, psc_n, sl_n, sh_n;
  logic [15:0] ctrl_o, own_o, tgt_o, cnt_o, psc_o, sl_o, sh_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  i2cm_regfile i_i2cm_regfile (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_new), .seq_set(seq_set), .seq_clr(seq_clr),
    .bus_busy(bus_busy), .irq(irq_new), .dma_rx_req(rx_new), .dma_tx_req(tx_new),
    .ctrl_out(ctrl_n), .own_addr(own_n), .tgt_addr(tgt_n), .xfer_count(cnt_n),
    .prescale(psc_n), .scl_low(sl_n), .scl_high(sh_n));

  i2cm_regfile #(.REV_ID(16'h0020)) i_i2cm_regfile_old (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rd_old), .seq_set(seq_set), .seq_clr(seq_clr),
    .bus_busy(bus_busy), .irq(irq_old), .dma_rx_req(rx_old), .dma_tx_req(tx_old),
    .ctrl_out(ctrl_o), .own_addr(own_o), .tgt_addr(tgt_o), .xfer_count(cnt_o),
    .prescale(psc_o), .scl_low(sl_o), .scl_high(sh_o));

  // {write, req, offset, wdata, expected readback on the new revision}
  localparam int TBL_N = 15;
  localparam logic [44:0] TBL [TBL_N] = '{
    {1'b1, 4'd2,  8'h04, 16'hFFFF, 16'h003F},  // R2 enable width
    {1'b1, 4'd4,  8'h14, 16'hFFFF, 16'h8080},  // R4 dma mask
    {1'b0, 4'd4,  8'h04, 16'h0000, 16'h0027},  // R4 enables 3,4 dropped
    {1'b1, 4'd8,  8'h24, 16'hFFFF, 16'hCF87},  // R8 control mask
    {1'b1, 4'd9,  8'h10, 16'h0000, 16'h0001},  // R9 enable bit mirror
    {1'b1, 4'd8,  8'h28, 16'hFFFF, 16'h03FF},  // R8 own address
    {1'b1, 4'd8,  8'h2C, 16'hABCD, 16'h03CD},  // R8 target address
    {1'b1, 4'd8,  8'h18, 16'h1234, 16'h1234},  // R8 count
    {1'b1, 4'd8,  8'h30, 16'h00FF, 16'h00FF},  // R8 prescaler
    {1'b1, 4'd8,  8'h34, 16'h5A5A, 16'h5A5A},  // R8 low time
    {1'b1, 4'd8,  8'h38, 16'hA5A5, 16'hA5A5},  // R8 high time
    {1'b1, 4'd9,  8'h00, 16'hFFFF, 16'h0034},  // R9 revision read-only
    {1'b1, 4'd9,  8'h20, 16'hFFFF, 16'h0000},  // R9 sysconfig
    {1'b1, 4'd9,  8'h1C, 16'hBEEF, 16'h0000},  // R9 data offset
    {1'b1, 4'd10, 8'h0C, 16'hFFFF, 16'h0000}   // R10 vector on new revision
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [5:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    seq_set = s; seq_clr = c;
    @(negedge clk);
    seq_set = '0; seq_clr = '0;
  endtask

  task automatic apply_reset;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", rd_new, 16'h0000);
    check("R1 irq/dma", {15'd0, irq_new | rx_new | tx_new}, 16'h0000);
    check("R1 ctrl_out", ctrl_n, 16'h0000);
    do_read(6'h08);
    check("R1 status", rd_new, 16'h0000);

    for (int k = 0; k < TBL_N; k++) begin
      if (TBL[k][44]) do_write(TBL[k][37:32], TBL[k][31:16]);
      do_read(TBL[k][37:32]);
      check($sformatf("R%0d table %0d", TBL[k][43:40], k), rd_new, TBL[k][15:0]);
    end
    check("R8 ctrl_out", ctrl_n, 16'hCF87);
    check("R8 tgt_addr", tgt_n, 16'h03CD);
    check("R8 scl_high", sh_n, 16'hA5A5);
    do_read(6'h04);
    check("R2 old enable after dma (R4)", rd_old, 16'h0007);
    do_read(6'h00);
    check("R9 old revision", rd_old, 16'h0020);

    // R13 hold without read, also across a write
    repeat (3) @(negedge clk);
    check("R13 hold idle", rd_old, 16'h0020);
    do_write(6'h18, 16'h9999);
    check("R13 hold on write", rd_new, 16'h0034);

    apply_reset;
    check("R1 rdata after reset", rd_new, 16'h0000);
    check("R1 prescale after reset", psc_n, 16'h0000);

    // R3 R5 interrupt and DMA requests
    do_write(6'h04, 16'h0018);
    pulse(16'h0008, 16'h0000);
    check("R3 irq on rrdy", {15'd0, irq_new}, 16'h0001);
    check("R5 rx idle", {15'd0, rx_new}, 16'h0000);
    do_write(6'h14, 16'h8000);
    check("R5 rx follows", {15'd0, rx_new}, 16'h0001);
    check("R4 irq drops with enable", {15'd0, irq_new}, 16'h0000);
    pulse(16'h0010, 16'h0000);
    check("R3 irq on xrdy", {15'd0, irq_new}, 16'h0001);
    check("R5 tx idle", {15'd0, tx_new}, 16'h0000);
    do_write(6'h14, 16'h0080);
    check("R5 tx/rx swap", {14'd0, tx_new, rx_new}, 16'h0002);
    check("R4 irq after tx dma", {15'd0, irq_new}, 16'h0000);

    // R6 strobes and busy bit
    apply_reset;
    pulse(16'h0400, 16'h0400);
    do_read(6'h08);
    check("R6 set beats clear", rd_new, 16'h0400);
    pulse(16'h0000, 16'h0400);
    bus_busy = 1'b1;
    do_read(6'h08);
    bus_busy = 1'b0;
    check("R6 clear and busy", rd_new, 16'h1000);

    // R7 write-one-to-clear
    pulse(16'h0C08, 16'h0000);
    do_write(6'h08, 16'h0008);
    do_read(6'h08);
    check("R7 new w1c", rd_new, 16'h0C00);
    check("R7 old ignores", rd_old, 16'h0C08);

    // R10 vector walk on old revision
    apply_reset;
    do_write(6'h04, 16'h0006);
    pulse(16'h0006, 16'h0000);
    do_read(6'h0C);
    check("R10 old vector 1", rd_old, 16'h0001);
    check("R10 new vector 0", rd_new, 16'h0000);
    do_read(6'h08);
    check("R10 old acked", rd_old, 16'h0004);
    check("R10 new untouched", rd_new, 16'h0006);
    do_read(6'h0C);
    check("R10 old vector 2", rd_old, 16'h0002);
    do_read(6'h0C);
    check("R10 old none", rd_old, 16'h0000);
    check("R10 old irq low (R3)", {15'd0, irq_old}, 16'h0000);

    // R11 self test
    do_write(6'h3C, 16'h8000);
    do_read(6'h3C);
    check("R11 first toggle", rd_new, 16'h800A);
    do_read(6'h3C);
    check("R11 second toggle", rd_new, 16'h8000);
    do_write(6'h3C, 16'h0005);
    do_read(6'h3C);
    do_read(6'h3C);
    check("R11 no toggle", rd_new, 16'h0005);
    do_write(6'h3C, 16'h7FFF);
    do_read(6'h3C);
    check("R11 mask", rd_old, 16'h780F);

    // R12 forced status fill
    apply_reset;
    do_write(6'h3C, 16'h0800);
    do_read(6'h08);
    check("R12 new fill", rd_new, 16'h003F);
    check("R12 old no fill", rd_old, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule